// File: doc/BRIEF.md
# Single-Wire Bus Master (HDQ and 1-Wire)

This block is a register-mapped master for a single open-drain data line. Depending on one control bit it uses either HDQ or 1-Wire slot timing. Software works through a byte-wide register port. It loads a transmit byte, sets a control word whose GO bit starts a transfer, and then collects the result from the receive register and the event flags. The transfer type follows three control bits:

- INIT selects a break/reset pulse with presence sampling.
- DIR selects receive instead of transmit.
- SINGLE limits a transfer to one bit, as needed by a 1-Wire ROM search.

The line is modelled as an output enable that pulls the wire low, plus a raw input that the block synchronizes. An external pull-up holds the wire high when nobody drives it. Every slot time is a parameter in clock cycles, with one set for each signalling mode.

A write to the configuration register can request a soft reset. The status register reports when that reset has finished. A level interrupt output reports pending events.

Top module: `swire_master`

## Requirements
- R1: After reset the register map has these values. Offset 0x00 reads the revision constant 0x21. Transmit data (0x04), receive data (0x08), control (0x0C) and event flags (0x10) read 0. Status bit 0 (0x18) reads 0 until RST_CYC clock edges after reset, then reads 1.
- R2: Control (0x0C) has these bits: 7 SINGLE, 6 interrupt enable, 5 clock enable, 4 GO, 3 presence (read-only), 2 INIT, 1 DIR, 0 mode. Writing GO=1 with INIT=0 and DIR=0 sends the transmit byte, least significant bit first. Exactly 8 slot lengths after the write edge, GO reads 0 and flag bit 2 is set.
- R3: GO=1 with DIR=1 receives 8 bits, least significant first, into the receive register. GO clears and flag bit 1 is set after 8 slot lengths.
- R4: With SINGLE=1 a transfer lasts one slot. A transmit sends bit 0 of the transmit byte. A receive returns the bit in bit 0 of the receive register, with bits 7..1 reading 0.
- R5: GO=1 with INIT=1 drives a break. Exactly break-end cycles after the write, GO and INIT read 0 and flag bit 0 is set. Control bit 3 reads 1 only if a slave held the line low at the presence sample point.
- R6: Reading the flag register (0x10) clears all three flags. A flag set in the same cycle as the read is kept.
- R7: The interrupt output is high exactly while interrupt enable is 1 and at least one flag is set.
- R8: While a transfer runs, writes to the control register are ignored. The running transfer keeps its type and timing.
- R9: Writing 1 to configuration bit 1 (0x14) aborts any transfer and releases the line. It also clears control, flags and transmit data, and drops status bit 0 for RST_CYC cycles.
- R10: Control bit 0 selects HDQ (0) or 1-Wire (1) timing. Slot and break lengths follow the parameter set of the selected mode.
- R11: A transmitted 0 drives the line low for LOW0 cycles of its mode and a 1 for LOW1 cycles. The line is never driven while no transfer runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Byte address of the register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Level interrupt |
| bus_oe_o | output | 1 | 1 pulls the data line low |
| bus_i | input | 1 | Raw level of the data line |

## Verification
Each transfer finishes on a fixed clock edge counted from the edge that wrote GO. A byte takes 8 slot lengths, a single bit one slot length, and a break its break-end length. The bench counts cycles while it watches GO at each falling edge, so it confirms the exact edge on which GO drops and the flags appear. Register results change on the edge that follows a write or a clearing read, and the bench samples them at the next falling edge. The status-done bit is checked at 0 immediately after a reset and at 1 exactly RST_CYC edges later.

// File: rtl/swire_pkg.sv
`timescale 1ns/1ps
// Shared constants of the single-wire master: register offsets, bit
// positions of the control and flag registers, and the transfer kind type.
// Assumes byte-wide registers on word-aligned byte offsets.
package swire_pkg;
    localparam int REG_AW = 5;
    localparam int DW     = 8;
    localparam int BCW    = $clog2(DW);

    localparam logic [REG_AW-1:0] A_REV = 5'h00;
    localparam logic [REG_AW-1:0] A_TXD = 5'h04;
    localparam logic [REG_AW-1:0] A_RXD = 5'h08;
    localparam logic [REG_AW-1:0] A_CTL = 5'h0C;
    localparam logic [REG_AW-1:0] A_IRQ = 5'h10;
    localparam logic [REG_AW-1:0] A_CFG = 5'h14;
    localparam logic [REG_AW-1:0] A_STA = 5'h18;

    localparam int C_SINGLE = 7;
    localparam int C_IE     = 6;
    localparam int C_CLKEN  = 5;
    localparam int C_GO     = 4;
    localparam int C_PRES   = 3;
    localparam int C_INIT   = 2;
    localparam int C_DIR    = 1;
    localparam int C_MODE   = 0;

    localparam int F_TXC = 2;
    localparam int F_RXC = 1;
    localparam int F_TMO = 0;

    typedef enum logic [1:0] {XF_TX, XF_RX, XF_BRK} xfer_e;
endpackage

// File: rtl/swire_regs.sv
`timescale 1ns/1ps
// Register file, event flags and interrupt of the single-wire master.
// Decodes writes, produces the one-cycle start request for the sequencer
// and the soft-reset pulse. Assumes the sequencer raises busy on the edge
// after start and holds it until the edge that ends its done cycle.
module swire_regs
    import swire_pkg::*;
#(
    parameter logic [7:0] REV_ID  = 8'h21,
    parameter int         RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              busy,
    input  logic              done,
    input  xfer_e             done_kind,
    input  logic [DW-1:0]     rx_byte,
    input  logic              presence,
    output logic              start,
    output xfer_e             kind,
    output logic              single,
    output logic              mode,
    output logic [DW-1:0]     tx_byte,
    output logic              srst,
    output logic              irq
);
    localparam int RCW = $clog2(RST_CYC + 1);

    logic [DW-1:0]  tx_q;
    logic           sgl_q, ie_q, cken_q, go_q, init_q, dir_q, mode_q, idle_q;
    logic [2:0]     flg_q, flg_set;
    logic [RCW-1:0] rc_q;
    logic           ctl_wr, flg_rd;

    assign ctl_wr  = wr && (addr == A_CTL) && !busy;
    assign flg_rd  = rd && (addr == A_IRQ);
    assign start   = ctl_wr && wdata[C_GO];
    assign kind    = wdata[C_INIT] ? XF_BRK : (wdata[C_DIR] ? XF_RX : XF_TX);
    assign single  = wdata[C_SINGLE];
    assign mode    = wdata[C_MODE];
    assign srst    = wr && (addr == A_CFG) && wdata[1];
    assign tx_byte = tx_q;
    assign irq     = ie_q && (flg_q != 3'b000);

    // Map a finished transfer to the flag it raises.
    always_comb begin
        flg_set = 3'b000;
        if (done) begin
            case (done_kind)
                XF_TX:   flg_set[F_TXC] = 1'b1;
                XF_RX:   flg_set[F_RXC] = 1'b1;
                default: flg_set[F_TMO] = 1'b1;
            endcase
        end
    end

    // Register state, flag set/clear and the reset-done counter.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            tx_q   <= '0;
            sgl_q  <= 1'b0; ie_q   <= 1'b0; cken_q <= 1'b0; go_q <= 1'b0;
            init_q <= 1'b0; dir_q  <= 1'b0; mode_q <= 1'b0; idle_q <= 1'b0;
            flg_q  <= '0;
            rc_q   <= '0;
        end else begin
            if (wr && (addr == A_TXD)) tx_q <= wdata;
            if (ctl_wr) begin
                sgl_q  <= wdata[C_SINGLE];
                ie_q   <= wdata[C_IE];
                cken_q <= wdata[C_CLKEN];
                go_q   <= wdata[C_GO];
                init_q <= wdata[C_INIT];
                dir_q  <= wdata[C_DIR];
                mode_q <= wdata[C_MODE];
            end else if (done) begin
                go_q <= 1'b0;
                if (done_kind == XF_BRK) init_q <= 1'b0;
            end
            if (wr && (addr == A_CFG)) idle_q <= wdata[0];
            flg_q <= (flg_rd ? 3'b000 : flg_q) | flg_set;
            if (rc_q != RCW'(RST_CYC)) rc_q <= rc_q + 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_REV:   rdata = REV_ID;
            A_TXD:   rdata = tx_q;
            A_RXD:   rdata = rx_byte;
            A_CTL:   rdata = {sgl_q, ie_q, cken_q, go_q, presence, init_q, dir_q, mode_q};
            A_IRQ:   rdata = {5'b0, flg_q};
            A_CFG:   rdata = {7'b0, idle_q};
            A_STA:   rdata = {7'b0, rc_q == RCW'(RST_CYC)};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/swire_seq.sv
`timescale 1ns/1ps
// Transfer sequencer and slot timer of the single-wire master. One counter
// times each slot; the low time, the sample point and the slot end are
// chosen per transfer kind and per signalling mode. Assumes the break end
// is the longest time in either mode and every sample point lies before
// its slot end.
module swire_seq
    import swire_pkg::*;
#(
    parameter int H_SLOT = 40, parameter int H_LOW0 = 30, parameter int H_LOW1 = 8,
    parameter int H_RDLOW = 4, parameter int H_RDSMP = 20,
    parameter int H_BRKLOW = 50, parameter int H_PRSMP = 70, parameter int H_BRKEND = 120,
    parameter int W_SLOT = 60, parameter int W_LOW0 = 50, parameter int W_LOW1 = 6,
    parameter int W_RDLOW = 6, parameter int W_RDSMP = 14,
    parameter int W_BRKLOW = 80, parameter int W_PRSMP = 110, parameter int W_BRKEND = 160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          start,
    input  xfer_e         kind,
    input  logic          single,
    input  logic          mode,
    input  logic [DW-1:0] tx_byte,
    input  logic          bus_i,
    output logic          bus_oe,
    output logic          busy,
    output logic          done,
    output xfer_e         done_kind,
    output logic [DW-1:0] rx_byte,
    output logic          presence
);
    localparam int TMAX = (H_BRKEND > W_BRKEND) ? H_BRKEND : W_BRKEND;
    localparam int TW   = $clog2(TMAX + 1);

    logic [1:0]     sync_q;
    logic           busy_q, mode_q, single_q, pres_q;
    xfer_e          kind_q;
    logic [TW-1:0]  t_q;
    logic [BCW-1:0] bit_q;
    logic [DW-1:0]  sh_q, rx_q;
    logic [TW-1:0]  t_slot, t_low0, t_low1, t_rdlow, t_rdsmp, t_brklow, t_prsmp, t_brkend;
    logic [TW-1:0]  low_len, end_pt;
    logic           in_s, last, at_end;

    assign in_s = sync_q[1];

    // Two-flop synchronizer for the raw line level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], bus_i};
    end

    // Pick the timing set of the latched signalling mode.
    always_comb begin
        if (mode_q) begin
            t_slot = TW'(W_SLOT);    t_low0 = TW'(W_LOW0);   t_low1 = TW'(W_LOW1);
            t_rdlow = TW'(W_RDLOW);  t_rdsmp = TW'(W_RDSMP); t_brklow = TW'(W_BRKLOW);
            t_prsmp = TW'(W_PRSMP);  t_brkend = TW'(W_BRKEND);
        end else begin
            t_slot = TW'(H_SLOT);    t_low0 = TW'(H_LOW0);   t_low1 = TW'(H_LOW1);
            t_rdlow = TW'(H_RDLOW);  t_rdsmp = TW'(H_RDSMP); t_brklow = TW'(H_BRKLOW);
            t_prsmp = TW'(H_PRSMP);  t_brkend = TW'(H_BRKEND);
        end
    end

    // Low time and last count of the current slot.
    always_comb begin
        case (kind_q)
            XF_TX:   low_len = sh_q[0] ? t_low1 : t_low0;
            XF_RX:   low_len = t_rdlow;
            default: low_len = t_brklow;
        endcase
        end_pt = ((kind_q == XF_BRK) ? t_brkend : t_slot) - TW'(1);
    end

    assign last      = single_q || (bit_q == BCW'(DW - 1));
    assign at_end    = busy_q && (t_q == end_pt);
    assign done      = at_end && ((kind_q == XF_BRK) || last);
    assign bus_oe    = busy_q && (t_q < low_len);
    assign busy      = busy_q;
    assign done_kind = kind_q;
    assign rx_byte   = rx_q;
    assign presence  = pres_q;

    // Start, slot counting, sampling, shifting and completion.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            busy_q <= 1'b0; mode_q <= 1'b0; single_q <= 1'b0; pres_q <= 1'b0;
            kind_q <= XF_TX; t_q <= '0; bit_q <= '0; sh_q <= '0; rx_q <= '0;
        end else if (start && !busy_q) begin
            busy_q   <= 1'b1;
            kind_q   <= kind;
            mode_q   <= mode;
            single_q <= single;
            t_q      <= '0;
            bit_q    <= '0;
            sh_q     <= tx_byte;
            if (kind == XF_BRK) pres_q <= 1'b0;
        end else if (busy_q) begin
            t_q <= t_q + 1'b1;
            if ((kind_q == XF_RX) && (t_q == t_rdsmp)) sh_q <= {in_s, sh_q[DW-1:1]};
            if ((kind_q == XF_BRK) && (t_q == t_prsmp)) pres_q <= !in_s;
            if (at_end) begin
                t_q <= '0;
                if (done) begin
                    busy_q <= 1'b0;
                    if (kind_q == XF_RX) rx_q <= single_q ? {{(DW-1){1'b0}}, sh_q[DW-1]} : sh_q;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    if (kind_q == XF_TX) sh_q <= {1'b0, sh_q[DW-1:1]};
                end
            end
        end
    end
endmodule

// File: rtl/swire_master.sv
`timescale 1ns/1ps
// Top of the single-wire bus master: register file plus sequencer.
// Assumes bus_i is the raw, unsynchronized wire level with an external
// pull-up; bus_oe_o high means the wire is pulled low.
module swire_master
    import swire_pkg::*;
#(
    parameter logic [7:0] REV_ID = 8'h21,
    parameter int RST_CYC = 4,
    parameter int H_SLOT = 40, parameter int H_LOW0 = 30, parameter int H_LOW1 = 8,
    parameter int H_RDLOW = 4, parameter int H_RDSMP = 20,
    parameter int H_BRKLOW = 50, parameter int H_PRSMP = 70, parameter int H_BRKEND = 120,
    parameter int W_SLOT = 60, parameter int W_LOW0 = 50, parameter int W_LOW1 = 6,
    parameter int W_RDLOW = 6, parameter int W_RDSMP = 14,
    parameter int W_BRKLOW = 80, parameter int W_PRSMP = 110, parameter int W_BRKEND = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq_o,
    output logic              bus_oe_o,
    input  logic              bus_i
);
    logic          x_start, x_single, x_mode, x_srst, x_busy, x_done, x_pres;
    xfer_e         x_kind, x_done_kind;
    logic [DW-1:0] x_tx, x_rx;

    swire_regs #(.REV_ID(REV_ID), .RST_CYC(RST_CYC)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(x_busy), .done(x_done),
        .done_kind(x_done_kind), .rx_byte(x_rx), .presence(x_pres),
        .start(x_start), .kind(x_kind), .single(x_single), .mode(x_mode),
        .tx_byte(x_tx), .srst(x_srst), .irq(irq_o)
    );

    swire_seq #(
        .H_SLOT(H_SLOT), .H_LOW0(H_LOW0), .H_LOW1(H_LOW1), .H_RDLOW(H_RDLOW),
        .H_RDSMP(H_RDSMP), .H_BRKLOW(H_BRKLOW), .H_PRSMP(H_PRSMP), .H_BRKEND(H_BRKEND),
        .W_SLOT(W_SLOT), .W_LOW0(W_LOW0), .W_LOW1(W_LOW1), .W_RDLOW(W_RDLOW),
        .W_RDSMP(W_RDSMP), .W_BRKLOW(W_BRKLOW), .W_PRSMP(W_PRSMP), .W_BRKEND(W_BRKEND)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .srst(x_srst), .start(x_start), .kind(x_kind),
        .single(x_single), .mode(x_mode), .tx_byte(x_tx), .bus_i(bus_i),
        .bus_oe(bus_oe_o), .busy(x_busy), .done(x_done), .done_kind(x_done_kind),
        .rx_byte(x_rx), .presence(x_pres)
    );
endmodule

// File: rtl/swire_master_chk.sv
`timescale 1ns/1ps
// Protocol checker for the single-wire master, attached by bind. It watches
// the start/done handshake between register file and sequencer, the line
// enable, the clear-on-read and the soft reset.
module swire_master_chk
    import swire_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              srst,
    input logic              bus_oe_o,
    input logic              irq_o,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr
);
    assert_oe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_oe_o);
    assert_go_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == A_IRQ) && !done) |=> !irq_o);
    assert_srst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && !bus_oe_o));
endmodule

bind swire_master swire_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(x_start), .busy(x_busy), .done(x_done),
    .srst(x_srst), .bus_oe_o(bus_oe_o), .irq_o(irq_o), .reg_rd(reg_rd),
    .reg_addr(reg_addr)
);

// File: tb/swire_master_tb.sv
`timescale 1ns/1ps
// Sweeping bench for the single-wire master with a behavioural slave.
module swire_master_tb;
    import swire_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_o, bus_oe_o, bus_i;

    int vecs = 0, miss = 0;

    // slave model state
    logic       cap_en = 0, resp_en = 0, pres_en = 0;
    logic [7:0] resp = '0, cap = '0;
    logic [2:0] ridx = '0;
    int lowc = 0, lastlow = 0, ncap = 0, pull_cnt = 0, pres_dly = 0;
    int wthr = 19, brk_thr = 35;

    always #5 clk = ~clk;

    assign bus_i = !(bus_oe_o || (pull_cnt != 0));

    swire_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .bus_oe_o(bus_oe_o), .bus_i(bus_i)
    );

    function automatic int slot_of(int m);   return m ? 60 : 40;  endfunction
    function automatic int low0_of(int m);   return m ? 50 : 30;  endfunction
    function automatic int low1_of(int m);   return m ? 6 : 8;    endfunction
    function automatic int brkend_of(int m); return m ? 160 : 120; endfunction

    // Slave: decodes write slots by low time, answers read slots and breaks.
    always @(posedge clk) begin
        if (pull_cnt > 0) pull_cnt <= pull_cnt - 1;
        if (pres_dly > 0) begin
            pres_dly <= pres_dly - 1;
            if (pres_dly == 1) pull_cnt <= 40;
        end
        if (!resp_en) ridx <= '0;
        if (bus_oe_o) begin
            lowc <= lowc + 1;
            if (lowc == 0 && resp_en) begin
                if (!resp[ridx]) pull_cnt <= 25;
                ridx <= ridx + 1'b1;
            end
        end else if (lowc != 0) begin
            lastlow <= lowc;
            lowc <= 0;
            if (lowc > brk_thr) begin
                if (pres_en) pres_dly <= 10;
            end else if (cap_en) begin
                cap  <= {(lowc < wthr), cap[7:1]};
                ncap <= ncap + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a; #1 d = reg_rdata;
    endtask

    // Counts falling edges after the GO write edge until GO reads 0.
    task automatic wait_go(output int n);
        n = 0;
        reg_addr = A_CTL;
        while (n < 5000) begin
            #1;
            if (!reg_rdata[C_GO]) break;
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #1_800_000;
        miss++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n, n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        peek(A_STA, d); chk("R1 status before done", d, 0);
        repeat (4) @(negedge clk);
        peek(A_STA, d); chk("R1 status done", d, 1);
        peek(A_REV, d); chk("R1 revision", d, 8'h21);
        peek(A_CTL, d); chk("R1 control", d, 0);
        peek(A_IRQ, d); chk("R1 flags", d, 0);
        peek(A_RXD, d); chk("R1 rx data", d, 0);
        peek(A_TXD, d); chk("R1 tx data", d, 0);
        chk("R1 irq", irq_o, 0);
        chk("R11 idle line", bus_oe_o, 0);

        for (int m = 0; m < 2; m++) begin
            wthr    = (low0_of(m) + low1_of(m)) / 2;
            brk_thr = low0_of(m) + 5;
            // R2 / R10 transmit sweep
            for (int k = 0; k < 8; k++) begin
                logic [7:0] v;
                v = (k == 0) ? 8'h00 : (k == 7) ? 8'hFF : 8'((k * 37 + m * 11) & 255);
                cap_en = 1;
                wr(A_TXD, v);
                wr(A_CTL, 8'h70 | 8'(m));
                wait_go(n);
                chk("R2 R10 tx cycles", n, 8 * slot_of(m));
                repeat (2) @(negedge clk);
                chk("R2 tx byte on line", cap, v);
                chk("R7 irq raised", irq_o, 1);
                rd(A_IRQ, d); chk("R2 tx flag", d, 8'h04);
                chk("R6 irq after clear", irq_o, 0);
                rd(A_IRQ, d); chk("R6 flags cleared", d, 0);
                cap_en = 0;
            end
            // R3 receive sweep
            for (int k = 0; k < 8; k++) begin
                logic [7:0] v;
                v = (k == 0) ? 8'hFF : (k == 7) ? 8'h00 : 8'((k * 53 + m * 29 + 3) & 255);
                resp = v; resp_en = 1;
                wr(A_CTL, 8'h72 | 8'(m));
                wait_go(n);
                chk("R3 R10 rx cycles", n, 8 * slot_of(m));
                rd(A_RXD, d); chk("R3 rx byte", d, v);
                rd(A_IRQ, d); chk("R3 rx flag", d, 8'h02);
                resp_en = 0;
                repeat (2) @(negedge clk);
            end
            // R4 / R11 single-bit transfers
            for (int b = 0; b < 2; b++) begin
                cap_en = 1; n0 = ncap;
                wr(A_TXD, 8'hA4 | 8'(b));
                wr(A_CTL, 8'hF0 | 8'(m));
                wait_go(n);
                chk("R4 single tx cycles", n, slot_of(m));
                repeat (2) @(negedge clk);
                chk("R4 single tx one slot", ncap - n0, 1);
                chk("R4 single tx bit", cap[7], b);
                chk("R11 low time", lastlow, b ? low1_of(m) : low0_of(m));
                rd(A_IRQ, d); chk("R4 single tx flag", d, 8'h04);
                cap_en = 0;
                resp = b ? 8'hFF : 8'h00; resp_en = 1;
                wr(A_CTL, 8'hF2 | 8'(m));
                wait_go(n);
                chk("R4 single rx cycles", n, slot_of(m));
                rd(A_RXD, d); chk("R4 single rx bit", d, b);
                rd(A_IRQ, d); chk("R4 single rx flag", d, 8'h02);
                resp_en = 0;
                repeat (2) @(negedge clk);
            end
            // R5 break with and without presence
            for (int p = 0; p < 2; p++) begin
                pres_en = p[0];
                wr(A_CTL, 8'h74 | 8'(m));
                wait_go(n);
                chk("R5 break cycles", n, brkend_of(m));
                rd(A_CTL, d); chk("R5 control after break", d, 8'h60 | 8'(m) | 8'(p << 3));
                rd(A_IRQ, d); chk("R5 timeout flag", d, 8'h01);
                pres_en = 0;
                repeat (50) @(negedge clk);
            end
            // R7 interrupt disabled: flag set, output stays low
            wr(A_CTL, 8'h34 | 8'(m));
            wait_go(n);
            repeat (2) @(negedge clk);
            chk("R7 irq masked", irq_o, 0);
            rd(A_IRQ, d); chk("R7 flag while masked", d, 8'h01);
        end

        // R8 control write during a transfer is ignored
        wthr = 28; brk_thr = 55; cap_en = 1;
        wr(A_TXD, 8'h3C);
        wr(A_CTL, 8'h71);
        repeat (20) @(negedge clk);
        wr(A_CTL, 8'h73);
        wait_go(n);
        chk("R8 timing kept", n, 8 * 60 - 22);
        repeat (2) @(negedge clk);
        chk("R8 byte kept", cap, 8'h3C);
        rd(A_CTL, d); chk("R8 control unchanged", d, 8'h61);
        rd(A_IRQ, d); chk("R8 only tx flag", d, 8'h04);
        cap_en = 0;

        // R9 soft reset aborts a transfer
        wr(A_TXD, 8'h00);
        wr(A_CTL, 8'h71);
        repeat (10) @(negedge clk);
        wr(A_CFG, 8'h02);
        chk("R9 line released", bus_oe_o, 0);
        peek(A_STA, d); chk("R9 status dropped", d, 0);
        peek(A_CTL, d); chk("R9 control cleared", d, 0);
        peek(A_TXD, d); chk("R9 tx cleared", d, 0);
        repeat (4) @(negedge clk);
        peek(A_STA, d); chk("R9 status done", d, 1);
        repeat (100) @(negedge clk);
        peek(A_IRQ, d); chk("R9 no flag after abort", d, 0);
        chk("R9 line idle", bus_oe_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule